// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a physical address by reading translation tables from memory, one doubleword at a time. A request carries the virtual address and a hypervisor flag. The block also reads three static inputs: a partition table control word, a partition ID and a process ID. It reads the partition entry for the effective partition. That entry gives the base of the process table, and the block reads the process entry for the effective process. The process entry gives the tree size and the root directory. The block then descends through the directory levels, each of which sets its own index width, until an entry marked as a leaf appears. It returns the physical address or a fault flag.

Only one walk is in progress at a time. Both the request side and the result side use a valid/ready handshake. The memory side is a 64-bit read port: an address request with valid/ready, and a response with a valid strobe. Exactly one response is taken in each wait state.

The controller has eight states:
- `S_IDLE` accepts a request. It goes to `S_PAT_REQ`, or to `S_DONE` on a bad quadrant.
- `S_PAT_REQ` moves to `S_PAT_WAIT` when the memory accepts the request.
- `S_PAT_WAIT` moves to `S_PRC_REQ` when the response arrives.
- `S_PRC_REQ` moves to `S_PRC_WAIT`.
- `S_PRC_WAIT` moves to `S_DIR_REQ`, or to `S_DONE` on a bad root geometry.
- `S_DIR_REQ` moves to `S_DIR_WAIT`.
- `S_DIR_WAIT` moves back to `S_DIR_REQ` for a directory entry. It moves to `S_DONE` for a leaf, an invalid entry or a bad geometry.
- `S_DONE` returns to `S_IDLE` once the result is accepted.

Top module: `radix_walker`

## Requirements
- R1: During and right after reset, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk is at `{ctl_word[55:12],12'h0} + effLPID*16 + 8`. effLPID is 0 when `req_hv` is 1 and `part_id` otherwise.
- R3: The second read is at `{E[55:12],12'h0} + effPID*16`, where E is the first response. effPID is `proc_id` when `req_vaddr[63:62]` is 2'b00 and 0 when it is 2'b11.
- R4: A request whose `req_vaddr[63:62]` is 2'b01 or 2'b10 completes with a fault and issues no memory read.
- R5: In the process entry P, the number of translated bits is `{P[62:61],P[7:5]} + 31`. The root base is `{P[55:8],8'h0}` and the root index width is `P[4:0]`.
- R6: At each level with base B, width W and remaining bits N, the entry is read at `B + (((vaddr >> (N-W)) & ((1<<W)-1)) * 8)`, and N becomes N-W for the next level.
- R7: In a tree entry D, bit 63 is valid and bit 62 is leaf. A valid non-leaf entry continues the walk with base `{D[55:8],8'h0}` and width `D[4:0]`.
- R8: For a valid leaf with N remaining bits and M = (1<<N)-1, the result is `({D[55:12],12'h0} & ~M) | (vaddr & M)` with no fault.
- R9: An entry whose bit 63 is 0 ends the walk with a fault, physical address 0 and no further reads.
- R10: A level width of 0, or one that would leave fewer than 12 remaining bits, ends the walk with a fault before that level is read.
- R11: `mem_req_valid` stays high with a stable address until `mem_req_ready`, and each read consumes exactly one response. The result stays valid and stable until `rsp_ready`, and new requests are accepted only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Effective address to translate |
| req_hv | input | 1 | Hypervisor flag of the request |
| ctl_word | input | 64 | Partition table control word (base in bits 55:12) |
| part_id | input | LPID_W | Partition ID used when not in hypervisor mode |
| proc_id | input | PID_W | Process ID used for quadrant 0 |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_fault | output | 1 | Walk failed |
| rsp_paddr | output | 64 | Physical address, 0 on fault |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Doubleword address to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data |

## Verification
The bench sweeps four root and second-level width pairs, with an 8-by-8 grid of root and second-level indices for each pair. The grid lands on leaves at depth one, two and three, on invalid entries, and on zero-width and oversized-width directories. This separates the leaf merge from the index arithmetic and from the two fault paths. Quadrant 0b00 and 0b11 addresses, the hypervisor flag and a non-zero partition ID each select different partition and process entries, so a wrong effective ID shows up as a wrong read address. Two extra cases use hand-computed physical addresses, and a third uses an illegal quadrant, where no memory read is allowed. Memory back-pressure and held results exercise the handshake rules.

// File: rtl/rw_pkg.sv
package rw_pkg;

    localparam int unsigned WORD_W = 64;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PAT_REQ,
        S_PAT_WAIT,
        S_PRC_REQ,
        S_PRC_WAIT,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_DONE
    } walk_state_t;

    // 4 KiB aligned base held in bits 55:12 of a word
    function automatic logic [WORD_W-1:0] page_field(input logic [WORD_W-1:0] w);
        return {8'h00, w[55:12], 12'h000};
    endfunction

    // 256-byte aligned directory base held in bits 55:8
    function automatic logic [WORD_W-1:0] dir_field(input logic [WORD_W-1:0] w);
        return {8'h00, w[55:8], 8'h00};
    endfunction

    function automatic logic [4:0] width_field(input logic [WORD_W-1:0] w);
        return w[4:0];
    endfunction

    // translated bit count: split size field plus 31
    function automatic logic [6:0] tree_bits(input logic [WORD_W-1:0] w);
        return 7'({w[62:61], w[7:5]}) + 7'd31;
    endfunction

    function automatic logic entry_valid(input logic [WORD_W-1:0] w);
        return w[63];
    endfunction

    function automatic logic entry_leaf(input logic [WORD_W-1:0] w);
        return w[62];
    endfunction

endpackage

// File: rtl/rw_level_step.sv
module rw_level_step #(
    parameter int REM_W   = 7,
    parameter int SZ_W    = 5,
    parameter int MIN_REM = 12
) (
    input  logic [63:0]      vaddr,
    input  logic [REM_W-1:0] remain,
    input  logic [63:0]      base,
    input  logic [SZ_W-1:0]  size,
    output logic [63:0]      entry_addr,
    output logic [REM_W-1:0] remain_next,
    output logic             bad
);
    logic [REM_W-1:0] size_ext;
    logic [63:0]      idx_mask;
    logic [63:0]      idx;

    always_comb begin
        size_ext    = REM_W'(size);
        bad         = (size == '0) || (remain < size_ext + REM_W'(MIN_REM));
        remain_next = remain - size_ext;
        idx_mask    = (64'd1 << size) - 64'd1;
        idx         = (vaddr >> remain_next) & idx_mask;
        entry_addr  = base + (idx << 3);
    end
endmodule

// File: rtl/rw_leaf_merge.sv
module rw_leaf_merge #(
    parameter int REM_W = 7
) (
    input  logic [63:0]      vaddr,
    input  logic [REM_W-1:0] remain,
    input  logic [63:0]      page_base,
    output logic [63:0]      paddr
);
    logic [63:0] off_mask;

    always_comb begin
        off_mask = (64'd1 << remain) - 64'd1;
        paddr    = (page_base & ~off_mask) | (vaddr & off_mask);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker #(
    parameter int LPID_W     = 12,
    parameter int PID_W      = 20,
    parameter int MIN_REMAIN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_vaddr,
    input  logic              req_hv,
    input  logic [63:0]       ctl_word,
    input  logic [LPID_W-1:0] part_id,
    input  logic [PID_W-1:0]  proc_id,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [63:0]       rsp_paddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    import rw_pkg::*;

    localparam int REM_W      = 7;
    localparam int SZ_W       = 5;
    localparam int ENTRY_SH   = 4;   // 16-byte table entries
    localparam int SECOND_OFF = 8;   // second doubleword of an entry

    walk_state_t       state_q, state_d;
    logic [63:0]       vaddr_q, vaddr_d;
    logic [63:0]       addr_q, addr_d;
    logic [63:0]       paddr_q, paddr_d;
    logic [REM_W-1:0]  remain_q, remain_d;
    logic [PID_W-1:0]  epid_q, epid_d;
    logic              fault_q, fault_d;

    logic [1:0]        quad;
    logic              quad_bad;
    logic [LPID_W-1:0] eff_lpid;

    logic [REM_W-1:0]  step_remain;
    logic [63:0]       step_addr;
    logic [REM_W-1:0]  step_next;
    logic              step_bad;
    logic [63:0]       leaf_paddr;

    logic unused_bits;
    assign unused_bits = ^{ctl_word[63:56], ctl_word[11:0], mem_rsp_data[60:56]};

    assign quad     = req_vaddr[63:62];
    assign quad_bad = (quad == 2'b01) || (quad == 2'b10);
    assign eff_lpid = req_hv ? '0 : part_id;

    // root level takes its bit count from the process entry, deeper levels from the register
    assign step_remain = (state_q == S_PRC_WAIT) ? tree_bits(mem_rsp_data) : remain_q;

    rw_level_step #(
        .REM_W   (REM_W),
        .SZ_W    (SZ_W),
        .MIN_REM (MIN_REMAIN)
    ) i_step (
        .vaddr       (vaddr_q),
        .remain      (step_remain),
        .base        (dir_field(mem_rsp_data)),
        .size        (width_field(mem_rsp_data)),
        .entry_addr  (step_addr),
        .remain_next (step_next),
        .bad         (step_bad)
    );

    rw_leaf_merge #(
        .REM_W (REM_W)
    ) i_leaf (
        .vaddr     (vaddr_q),
        .remain    (remain_q),
        .page_base (page_field(mem_rsp_data)),
        .paddr     (leaf_paddr)
    );

    // next-state and datapath
    always_comb begin
        state_d  = state_q;
        vaddr_d  = vaddr_q;
        addr_d   = addr_q;
        paddr_d  = paddr_q;
        remain_d = remain_q;
        epid_d   = epid_q;
        fault_d  = fault_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    vaddr_d = req_vaddr;
                    paddr_d = '0;
                    fault_d = 1'b0;
                    epid_d  = (quad == 2'b00) ? proc_id : '0;
                    addr_d  = page_field(ctl_word)
                            + (64'(eff_lpid) << ENTRY_SH) + 64'(SECOND_OFF);
                    if (quad_bad) begin
                        fault_d = 1'b1;
                        state_d = S_DONE;
                    end else begin
                        state_d = S_PAT_REQ;
                    end
                end
            end
            S_PAT_REQ: if (mem_req_ready) state_d = S_PAT_WAIT;
            S_PAT_WAIT: begin
                if (mem_rsp_valid) begin
                    addr_d  = page_field(mem_rsp_data) + (64'(epid_q) << ENTRY_SH);
                    state_d = S_PRC_REQ;
                end
            end
            S_PRC_REQ: if (mem_req_ready) state_d = S_PRC_WAIT;
            S_PRC_WAIT: begin
                if (mem_rsp_valid) begin
                    if (step_bad) begin
                        fault_d = 1'b1;
                        state_d = S_DONE;
                    end else begin
                        addr_d   = step_addr;
                        remain_d = step_next;
                        state_d  = S_DIR_REQ;
                    end
                end
            end
            S_DIR_REQ: if (mem_req_ready) state_d = S_DIR_WAIT;
            S_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!entry_valid(mem_rsp_data)) begin
                        fault_d = 1'b1;
                        state_d = S_DONE;
                    end else if (entry_leaf(mem_rsp_data)) begin
                        paddr_d = leaf_paddr;
                        state_d = S_DONE;
                    end else if (step_bad) begin
                        fault_d = 1'b1;
                        state_d = S_DONE;
                    end else begin
                        addr_d   = step_addr;
                        remain_d = step_next;
                        state_d  = S_DIR_REQ;
                    end
                end
            end
            S_DONE: if (rsp_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            vaddr_q  <= '0;
            addr_q   <= '0;
            paddr_q  <= '0;
            remain_q <= '0;
            epid_q   <= '0;
            fault_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            vaddr_q  <= vaddr_d;
            addr_q   <= addr_d;
            paddr_q  <= paddr_d;
            remain_q <= remain_d;
            epid_q   <= epid_d;
            fault_q  <= fault_d;
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_PAT_REQ) || (state_q == S_PRC_REQ)
                     || (state_q == S_DIR_REQ);
        mem_req_addr  = addr_q;
        rsp_valid     = (state_q == S_DONE);
        rsp_fault     = fault_q;
        rsp_paddr     = paddr_q;
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    // R11
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && !mem_req_valid);

    // R6
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    // R4
    quad_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid && (req_vaddr[63:62] == 2'b01 || req_vaddr[63:62] == 2'b10)
        |=> rsp_valid && rsp_fault);

    // R9
    invalid_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_DIR_WAIT && mem_rsp_valid && !mem_rsp_data[63]
        |=> rsp_valid && rsp_fault && rsp_paddr == 64'd0);

    // R10
    min_remain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_DIR_REQ |-> remain_q >= REM_W'(MIN_REMAIN));

endmodule

// File: tb/test_radix_walker.sv
module test_radix_walker;
    localparam int CLK_PERIOD = 10;
    localparam int LPID_W     = 12;
    localparam int PID_W      = 20;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_ready, req_hv;
    logic [63:0]       req_vaddr;
    logic [63:0]       ctl_word;
    logic [LPID_W-1:0] part_id;
    logic [PID_W-1:0]  proc_id;
    logic              rsp_valid, rsp_ready, rsp_fault;
    logic [63:0]       rsp_paddr;
    logic              mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [63:0]       mem_req_addr, mem_rsp_data;

    int checks = 0;
    int errors = 0;

    logic [63:0] mem [logic [63:0]];
    logic        pend = 1'b0;
    logic [63:0] pend_a = '0;
    int          nreads = 0;
    logic [63:0] rd_log [16];
    int          cyc = 0;

    logic        exp_fault;
    logic [63:0] exp_pa;
    int          exp_n;
    logic [63:0] exp_log [16];
    int          walk_no = 0;

    radix_walker #(.LPID_W(LPID_W), .PID_W(PID_W)) i_radix_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_hv(req_hv),
        .ctl_word(ctl_word), .part_id(part_id), .proc_id(proc_id),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rdm(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // memory model: record accepted requests, answer one per request
    always @(posedge clk) begin
        if (mem_rsp_valid) pend <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            pend   <= 1'b1;
            pend_a <= mem_req_addr;
            rd_log[nreads % 16] <= mem_req_addr;
            nreads <= nreads + 1;
        end
    end

    always @(negedge clk) begin
        cyc           = cyc + 1;
        mem_req_ready = (cyc % 3) != 1;
        mem_rsp_valid = pend && (cyc % 2 == 0);
        mem_rsp_data  = mem_rsp_valid ? rdm(pend_a) : 64'h0;
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (walk %0d)", tag, act, exp, walk_no);
        end
    endtask

    // reference walk computed from the requirements
    function automatic void ref_walk(input logic [63:0] va, input logic hv,
                                     input logic [LPID_W-1:0] lp, input logic [PID_W-1:0] pd);
        logic [63:0] a, d, base, m;
        int rem, sz, sh;
        logic [LPID_W-1:0] el;
        logic [PID_W-1:0]  ep;
        exp_fault = 1'b1;
        exp_pa    = 64'h0;
        exp_n     = 0;
        if (va[63:62] == 2'b01 || va[63:62] == 2'b10) return;
        el = hv ? '0 : lp;
        a  = {8'h0, ctl_word[55:12], 12'h0} + 64'(el) * 64'd16 + 64'd8;
        exp_log[exp_n] = a; exp_n++;
        d  = rdm(a);
        ep = (va[63:62] == 2'b00) ? pd : '0;
        a  = {8'h0, d[55:12], 12'h0} + 64'(ep) * 64'd16;
        exp_log[exp_n] = a; exp_n++;
        d  = rdm(a);
        rem  = int'({d[62:61], d[7:5]}) + 31;
        base = {8'h0, d[55:8], 8'h0};
        sz   = int'(d[4:0]);
        for (int lvl = 0; lvl < 14; lvl++) begin
            if (sz == 0 || rem - sz < 12) return;
            sh = rem - sz;
            a  = base + ((va >> sh) & ((64'h1 << sz) - 64'h1)) * 64'd8;
            exp_log[exp_n] = a; exp_n++;
            d   = rdm(a);
            rem = rem - sz;
            if (!d[63]) return;
            if (d[62]) begin
                m         = (64'h1 << rem) - 64'h1;
                exp_pa    = ({8'h0, d[55:12], 12'h0} & ~m) | (va & m);
                exp_fault = 1'b0;
                return;
            end
            base = {8'h0, d[55:8], 8'h0};
            sz   = int'(d[4:0]);
        end
    endfunction

    task automatic walk(input logic [63:0] va, input logic hv, input logic [LPID_W-1:0] lp,
                        input logic [PID_W-1:0] pd, input int hold,
                        output logic got_f, output logic [63:0] got_pa, output int got_n);
        int start;
        logic seq_ok;
        walk_no++;
        part_id = lp;
        proc_id = pd;
        ref_walk(va, hv, lp, pd);
        start     = nreads;
        req_vaddr = va;
        req_hv    = hv;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_f  = rsp_fault;
        got_pa = rsp_paddr;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk(rsp_valid && rsp_paddr == got_pa && rsp_fault == got_f,
                "R11 result held until accepted", rsp_paddr, got_pa);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        got_n = nreads - start;
        // against reference
        chk(got_f == exp_fault, "R9 R10 fault flag", 64'(got_f), 64'(exp_fault));
        chk(got_pa == (exp_fault ? 64'h0 : exp_pa), "R5 R7 R8 physical address",
            got_pa, exp_fault ? 64'h0 : exp_pa);
        chk(got_n == exp_n, "R11 read count", 64'(got_n), 64'(exp_n));
        seq_ok = 1'b1;
        for (int k = 0; k < 16; k++)
            if (k < got_n && k < exp_n && rd_log[(start + k) % 16] != exp_log[k]) seq_ok = 1'b0;
        chk(seq_ok, "R6 read address sequence", 64'(got_n), 64'(exp_n));
    endtask

    task automatic build(input int rs, input int ns);
        mem.delete();
        ctl_word = 64'h10004;
        mem[64'h10008] = 64'h0000_0000_0100_0000;                 // partition 0 -> 0x1000000
        mem[64'h10038] = 64'h0000_0000_0200_0000;                 // partition 3 -> 0x2000000
        mem[64'h0100_0000] = (64'd2 << 61) | 64'h30000 | (64'd5 << 5) | 64'(rs);
        mem[64'h0100_0010] = (64'd2 << 61) | 64'h38000 | (64'd5 << 5) | 64'(rs);
        mem[64'h0200_0000] = 64'h30000 | (64'd5 << 5) | 64'(rs);  // 36-bit tree
        mem[64'h38000] = (64'h3 << 62) | (64'h777 << 12);
        for (int i = 0; i < 8; i++) begin
            logic [63:0] ra;
            ra = 64'h30000 + 64'(i) * 8;
            case (i % 4)
                0: mem[ra] = (64'h1 << 63) | (64'h40000 + 64'(i) * 64'h1000) | 64'(ns);
                1: mem[ra] = (64'h3 << 62) | (64'(i) << 40);
                2: mem[ra] = 64'h0;
                default: mem[ra] = (64'h1 << 63) | 64'h48000;      // zero width
            endcase
            for (int j = 0; j < 8; j++) begin
                logic [63:0] sa;
                sa = 64'h40000 + 64'(i) * 64'h1000 + 64'(j) * 8;
                case (j % 3)
                    0: mem[sa] = (64'h3 << 62) | ((64'hABC00 + 64'(j) * 16 + 64'(i)) << 12);
                    1: mem[sa] = 64'h0;
                    default: mem[sa] = (64'h1 << 63) | 64'h60000 | ((j == 5) ? 64'd31 : 64'd4);
                endcase
            end
        end
        for (int k = 0; k < 16; k++)
            mem[64'h60000 + 64'(k) * 8] = (k % 2 == 0) ? ((64'h3 << 62) | ((64'h5000 + 64'(k)) << 12)) : 64'h0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic        f;
        logic [63:0] pa;
        int          n;
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_hv = 1'b0;
        rsp_ready = 1'b0; part_id = '0; proc_id = '0; ctl_word = '0;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
            "R1 reset outputs", {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
            "R1 after reset", {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

        build(13, 9);
        // hand-computed: process 1 root leaf, 39 offset bits
        walk(64'h1000, 1'b1, '0, 20'd1, 0, f, pa, n);
        chk(!f && pa == 64'h1000, "R8 quadrant 0 root leaf", pa, 64'h1000);
        chk(n == 3 && rd_log[(nreads - 2) % 16] == 64'h0100_0010, "R3 process entry address",
            rd_log[(nreads - 2) % 16], 64'h0100_0010);
        // hand-computed: quadrant 3, root entry 1 leaf with page base 1<<40
        walk(64'hC000_0080_0000_5678, 1'b1, '0, 20'd1, 2, f, pa, n);
        chk(!f && pa == 64'h0000_0100_0000_5678, "R8 quadrant 3 root leaf", pa, 64'h0000_0100_0000_5678);
        chk(rd_log[(nreads - 2) % 16] == 64'h0100_0000, "R3 quadrant 3 uses process 0",
            rd_log[(nreads - 2) % 16], 64'h0100_0000);
        // illegal quadrants
        walk(64'h4000_0000_0000_1000, 1'b1, '0, '0, 0, f, pa, n);
        chk(f && n == 0, "R4 quadrant 01 faults without reads", 64'(n), 64'h0);
        walk(64'h8000_0000_0000_1000, 1'b0, 12'd3, '0, 1, f, pa, n);
        chk(f && n == 0, "R4 quadrant 10 faults without reads", 64'(n), 64'h0);
        // partition 3 when not in hypervisor mode
        walk(64'h0000_0000_0000_2000, 1'b0, 12'd3, '0, 0, f, pa, n);
        chk(rd_log[(nreads - n) % 16] == 64'h10038, "R2 partition entry address",
            rd_log[(nreads - n) % 16], 64'h10038);
        walk(64'h0000_0000_0000_2000, 1'b1, 12'd3, '0, 0, f, pa, n);
        chk(rd_log[(nreads - n) % 16] == 64'h10008, "R2 hypervisor uses partition 0",
            rd_log[(nreads - n) % 16], 64'h10008);

        for (int cfg = 0; cfg < 4; cfg++) begin
            int rs, ns;
            rs = cfg[0] ? 13 : 9;
            ns = cfg[1] ? 9 : 5;
            build(rs, ns);
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [63:0] va;
                    va = (64'(i) << (52 - rs)) | (64'(j) << (52 - rs - ns))
                       | (64'((i + j) % 16) << (48 - rs - ns)) | 64'h0AB8;
                    if ((i + j) % 2 == 1) va = va | 64'hC000_0000_0000_0000;
                    walk(va, j[0], '0, '0, (i + j) % 3, f, pa, n);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule